// File: doc/BRIEF.md
# Fixed Wait-State Bus Adapter

This block lets a memory-mapped host that understands waitrequest talk to a synchronous target that has fixed access timing and no flow control of its own. The host presents address, byteenable, write data and a read or write strobe. The adapter captures the request and holds waitrequest high. It then drives the target's chip select, address, byteenable and write data through a setup phase, an access phase with the read or write strobe asserted, and a hold phase. The length of each phase is a cycle count fixed at build time.

To the host, the target behaves like an ordinary stalling slave. Waitrequest drops in the last strobe cycle, which is the cycle in which the transfer completes. For a read, the target's data is sampled at the end of that last strobe cycle. It is returned to the host in the next cycle with a one-cycle valid pulse.

All counts run in clock cycles of the single clock. Each count may be set from 0 to 1000, and each defaults to 0. The read and write access lengths are set separately. All signals driven to the target come from flops.

Top module: `fws_adapter`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select, both target strobes and read-valid are low. With no request pending, waitrequest is low.
- R2: After a request is captured, chip select, address, byteenable and write data are driven for exactly SETUP_CYC cycles before the read or write strobe rises.
- R3: A write strobe stays high for WR_WAIT_CYC+1 cycles. Waitrequest is low only in the final strobe cycle. A write presented while the adapter is idle stalls for 1+SETUP_CYC+WR_WAIT_CYC cycles.
- R4: A read strobe stays high for RD_WAIT_CYC+1 cycles, and a read presented while idle stalls for 1+SETUP_CYC+RD_WAIT_CYC cycles. The target's data from the final strobe cycle appears on h_rdata with h_rdvalid high for exactly one cycle, in the cycle after completion.
- R5: After the strobe drops, chip select and the address stay asserted for HOLD_CYC cycles. A request presented during the hold phase sees waitrequest high and is not captured until the hold phase ends, so it stalls for the remaining hold cycles as well.
- R6: Address, byteenable and write data reach the target unchanged from the host's values.
- R7: With all four counts at 0, every transfer stalls for exactly one cycle. The strobe is high only in the completion cycle.
- R8: When read and write are both asserted, the adapter performs a read.
- R9: At most one target strobe is high at a time, and a strobe is only ever high together with chip select.
- R10: From the first cycle of chip select until it drops, address, byteenable and write data do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every port |
| rst | input | 1 | Synchronous reset, active high |
| h_addr | input | ADDR_W | Host address |
| h_be | input | DATA_W/8 | Host byteenable |
| h_wdata | input | DATA_W | Host write data |
| h_rd | input | 1 | Host read request |
| h_wr | input | 1 | Host write request |
| h_waitreq | output | 1 | Stall to host; low in the completing cycle |
| h_rdata | output | DATA_W | Read data returned to host |
| h_rdvalid | output | 1 | One-cycle pulse qualifying h_rdata |
| t_cs | output | 1 | Target chip select |
| t_addr | output | ADDR_W | Target address |
| t_be | output | DATA_W/8 | Target byteenable |
| t_wdata | output | DATA_W | Target write data |
| t_rd | output | 1 | Target read strobe |
| t_wr | output | 1 | Target write strobe |
| t_rdata | input | DATA_W | Data from the target |

## Verification
The bound checker watches every cycle for strobe exclusivity, strobes only under chip select, and stable target fields while chip select is high. It also checks, with its own counters, the number of setup cycles before each strobe rise and the strobe length at completion, as well as the read-valid pulse and the hold-phase stall. Only the bench scenarios can show the end-to-end numbers the host sees: stall counts that include leftover hold cycles between back-to-back requests, the exact data and byteenable reaching the target, read data timed to the final strobe cycle, read precedence, and the one-cycle behaviour of a zero-count build.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_HOLD   = 2'd3
  } fws_state_e;

  // Largest of the four phase counts.
  function automatic int unsigned fws_max4(int unsigned a, int unsigned b,
                                           int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter width able to hold the largest count, never below one bit.
  function automatic int unsigned fws_cnt_bits(int unsigned max_cnt);
    return (max_cnt < 1) ? 1 : $clog2(max_cnt + 1);
  endfunction

  // A phase of n cycles loads n-1 into the down-counter.
  function automatic int unsigned fws_phase_load(int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // Host-visible stall of a request presented while idle.
  function automatic int unsigned fws_stall_cycles(int unsigned setup_n,
                                                   int unsigned wait_n);
    return 1 + setup_n + wait_n;
  endfunction

endpackage

// File: rtl/fws_capture.sv
module fws_capture #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [BE_W-1:0]   h_be,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              op_rd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BE_W-1:0]   be_q,
  output logic [DATA_W-1:0] wdata_q
);

  // The request fields are taken once, at capture, and held through
  // setup, access and hold.
  always_ff @(posedge clk) begin
    if (rst) begin
      op_rd_q <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (capture) begin
      op_rd_q <= req_rd;
      addr_q  <= h_addr;
      be_q    <= h_be;
      wdata_q <= h_wdata;
    end
  end

endmodule

// File: rtl/fws_seq.sv
module fws_seq
  import fws_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 0,
  parameter int unsigned RD_WAIT_CYC = 0,
  parameter int unsigned WR_WAIT_CYC = 0,
  parameter int unsigned HOLD_CYC    = 0,
  parameter int unsigned CNT_W       = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       req_rd,
  input  logic       op_rd_q,
  output fws_state_e state_q,
  output fws_state_e state_d,
  output logic       capture,
  output logic       nxt_rd,
  output logic       xfer_done,
  output logic       in_hold,
  output logic       waitreq
);

  localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(fws_phase_load(SETUP_CYC));
  localparam logic [CNT_W-1:0] HOLD_LOAD  = CNT_W'(fws_phase_load(HOLD_CYC));
  localparam logic [CNT_W-1:0] RD_LOAD    = CNT_W'(RD_WAIT_CYC);
  localparam logic [CNT_W-1:0] WR_LOAD    = CNT_W'(WR_WAIT_CYC);
  localparam bit HAS_SETUP = (SETUP_CYC != 0);
  localparam bit HAS_HOLD  = (HOLD_CYC != 0);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] access_load;
  logic             cnt_last;

  assign capture     = (state_q == ST_IDLE) && req;
  assign nxt_rd      = capture ? req_rd : op_rd_q;
  assign access_load = nxt_rd ? RD_LOAD : WR_LOAD;
  assign cnt_last    = (cnt_q == '0);
  assign xfer_done   = (state_q == ST_ACCESS) && cnt_last;
  assign in_hold     = (state_q == ST_HOLD);
  assign waitreq     = capture || ((state_q != ST_IDLE) && !xfer_done);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (HAS_SETUP) begin
            state_d = ST_SETUP;
            cnt_d   = SETUP_LOAD;
          end else begin
            state_d = ST_ACCESS;
            cnt_d   = access_load;
          end
        end
      end
      ST_SETUP: begin
        if (cnt_last) begin
          state_d = ST_ACCESS;
          cnt_d   = access_load;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACCESS: begin
        if (cnt_last) begin
          if (HAS_HOLD) begin
            state_d = ST_HOLD;
            cnt_d   = HOLD_LOAD;
          end else begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_last) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/fws_strobe.sv
module fws_strobe
  import fws_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  fws_state_e state_d,
  input  logic       nxt_rd,
  output logic       t_cs,
  output logic       t_rd,
  output logic       t_wr
);

  // Strobes are decoded from the next state and registered, so the
  // target sees clean flop outputs aligned with the state register.
  always_ff @(posedge clk) begin
    if (rst) begin
      t_cs <= 1'b0;
      t_rd <= 1'b0;
      t_wr <= 1'b0;
    end else begin
      t_cs <= (state_d != ST_IDLE);
      t_rd <= (state_d == ST_ACCESS) && nxt_rd;
      t_wr <= (state_d == ST_ACCESS) && !nxt_rd;
    end
  end

endmodule

// File: rtl/fws_rdret.sv
module fws_rdret #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] t_rdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_rdvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata   <= '0;
      h_rdvalid <= 1'b0;
    end else begin
      h_rdvalid <= rd_done;
      if (rd_done) h_rdata <= t_rdata;
    end
  end

endmodule

// File: rtl/fws_adapter.sv
module fws_adapter
  import fws_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SETUP_CYC   = 0,
  parameter int unsigned RD_WAIT_CYC = 0,
  parameter int unsigned WR_WAIT_CYC = 0,
  parameter int unsigned HOLD_CYC    = 0,
  localparam int unsigned BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [BE_W-1:0]   h_be,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              h_rd,
  input  logic              h_wr,
  output logic              h_waitreq,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_rdvalid,
  output logic              t_cs,
  output logic [ADDR_W-1:0] t_addr,
  output logic [BE_W-1:0]   t_be,
  output logic [DATA_W-1:0] t_wdata,
  output logic              t_rd,
  output logic              t_wr,
  input  logic [DATA_W-1:0] t_rdata
);

  localparam int unsigned MAX_CNT =
    fws_max4(SETUP_CYC, RD_WAIT_CYC, WR_WAIT_CYC, HOLD_CYC);
  localparam int unsigned CNT_W = fws_cnt_bits(MAX_CNT);

  fws_state_e state_q, state_d;
  logic       req;
  logic       capture;
  logic       nxt_rd;
  logic       op_rd_q;
  logic       xfer_done;
  logic       in_hold;
  logic       rd_done;

  // A read wins when both requests are raised together.
  assign req     = h_rd || h_wr;
  assign rd_done = xfer_done && op_rd_q;

  fws_seq #(
    .SETUP_CYC   (SETUP_CYC),
    .RD_WAIT_CYC (RD_WAIT_CYC),
    .WR_WAIT_CYC (WR_WAIT_CYC),
    .HOLD_CYC    (HOLD_CYC),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_rd    (h_rd),
    .op_rd_q   (op_rd_q),
    .state_q   (state_q),
    .state_d   (state_d),
    .capture   (capture),
    .nxt_rd    (nxt_rd),
    .xfer_done (xfer_done),
    .in_hold   (in_hold),
    .waitreq   (h_waitreq)
  );

  fws_capture #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_capture (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .req_rd  (h_rd),
    .h_addr  (h_addr),
    .h_be    (h_be),
    .h_wdata (h_wdata),
    .op_rd_q (op_rd_q),
    .addr_q  (t_addr),
    .be_q    (t_be),
    .wdata_q (t_wdata)
  );

  fws_strobe u_strobe (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .nxt_rd  (nxt_rd),
    .t_cs    (t_cs),
    .t_rd    (t_rd),
    .t_wr    (t_wr)
  );

  fws_rdret #(
    .DATA_W (DATA_W)
  ) u_rdret (
    .clk       (clk),
    .rst       (rst),
    .rd_done   (rd_done),
    .t_rdata   (t_rdata),
    .h_rdata   (h_rdata),
    .h_rdvalid (h_rdvalid)
  );

endmodule

// File: rtl/fws_adapter_chk.sv
module fws_adapter_chk #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SETUP_CYC   = 0,
  parameter int unsigned RD_WAIT_CYC = 0,
  parameter int unsigned WR_WAIT_CYC = 0,
  parameter int unsigned HOLD_CYC    = 0,
  localparam int unsigned BE_W       = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              h_waitreq,
  input logic              h_rdvalid,
  input logic              t_cs,
  input logic              t_rd,
  input logic              t_wr,
  input logic [ADDR_W-1:0] t_addr,
  input logic [BE_W-1:0]   t_be,
  input logic [DATA_W-1:0] t_wdata,
  input logic              xfer_done,
  input logic              in_hold
);

  logic        strobe;
  logic        seen_strobe;
  logic [10:0] su_cnt;
  logic [10:0] st_cnt;

  assign strobe = t_rd || t_wr;

  // Setup cycles seen since chip select rose, and strobe cycles so far.
  always_ff @(posedge clk) begin
    if (rst || !t_cs) begin
      su_cnt      <= '0;
      seen_strobe <= 1'b0;
    end else begin
      if (strobe) seen_strobe <= 1'b1;
      else if (!seen_strobe) su_cnt <= su_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe) st_cnt <= '0;
    else                st_cnt <= st_cnt + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!t_cs && !t_rd && !t_wr && !h_rdvalid));

  p_setup_len_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> (32'(su_cnt) == SETUP_CYC));

  // Covers R3 for writes and R4 for reads.
  p_strobe_len_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (32'(st_cnt) == (t_rd ? RD_WAIT_CYC : WR_WAIT_CYC)));

  p_strobe_at_done_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> strobe);

  p_strobe_ends_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !strobe);

  p_rdvalid_after_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && t_rd) |=> h_rdvalid);

  p_rdvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    h_rdvalid |=> !h_rdvalid);

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (rst)
    in_hold |-> (h_waitreq && t_cs && !strobe));

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(t_rd && t_wr));

  p_strobe_cs_r9: assert property (@(posedge clk) disable iff (rst)
    strobe |-> t_cs);

  p_fields_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (t_cs && $past(t_cs)) |-> ($stable(t_addr) && $stable(t_be) && $stable(t_wdata)));

endmodule

bind fws_adapter fws_adapter_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .SETUP_CYC   (SETUP_CYC),
  .RD_WAIT_CYC (RD_WAIT_CYC),
  .WR_WAIT_CYC (WR_WAIT_CYC),
  .HOLD_CYC    (HOLD_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .h_waitreq (h_waitreq),
  .h_rdvalid (h_rdvalid),
  .t_cs      (t_cs),
  .t_rd      (t_rd),
  .t_wr      (t_wr),
  .t_addr    (t_addr),
  .t_be      (t_be),
  .t_wdata   (t_wdata),
  .xfer_done (xfer_done),
  .in_hold   (in_hold)
);

// File: tb/fws_adapter_bench.sv
module fws_adapter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int BW  = DW / 8;
  localparam int SU  = 2;
  localparam int RDW = 3;
  localparam int WRW = 1;
  localparam int HO  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Main instance signals
  logic [AW-1:0] h_addr = '0;
  logic [BW-1:0] h_be = '0;
  logic [DW-1:0] h_wdata = '0;
  logic          h_rd = 1'b0, h_wr = 1'b0;
  logic          h_waitreq, h_rdvalid;
  logic [DW-1:0] h_rdata;
  logic          t_cs, t_rd, t_wr;
  logic [AW-1:0] t_addr;
  logic [BW-1:0] t_be;
  logic [DW-1:0] t_wdata, t_rdata;

  // Zero-count instance signals
  logic [AW-1:0] z_h_addr = '0;
  logic [BW-1:0] z_h_be = '0;
  logic [DW-1:0] z_h_wdata = '0;
  logic          z_h_rd = 1'b0, z_h_wr = 1'b0;
  logic          z_h_waitreq, z_h_rdvalid;
  logic [DW-1:0] z_h_rdata;
  logic          z_t_cs, z_t_rd, z_t_wr;
  logic [AW-1:0] z_t_addr;
  logic [BW-1:0] z_t_be;
  logic [DW-1:0] z_t_wdata, z_t_rdata;

  int vec_cnt = 0;
  int mis_cnt = 0;

  function automatic logic [DW-1:0] tgt_word(logic [AW-1:0] a);
    return {~a, a} ^ 32'h5a5a_0000;
  endfunction

  // Target model: data is only valid in the final read strobe cycle.
  int tb_rd_age = 0;
  always @(posedge clk) tb_rd_age <= t_rd ? tb_rd_age + 1 : 0;
  assign t_rdata   = (t_rd && tb_rd_age == RDW) ? tgt_word(t_addr) : 32'hDEAD_BEEF;
  assign z_t_rdata = z_t_rd ? tgt_word(z_t_addr) : 32'hDEAD_BEEF;

  fws_adapter #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .RD_WAIT_CYC(RDW),
    .WR_WAIT_CYC(WRW), .HOLD_CYC(HO)
  ) u_fws_adapter (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
    .h_rd(h_rd), .h_wr(h_wr), .h_waitreq(h_waitreq), .h_rdata(h_rdata),
    .h_rdvalid(h_rdvalid), .t_cs(t_cs), .t_addr(t_addr), .t_be(t_be),
    .t_wdata(t_wdata), .t_rd(t_rd), .t_wr(t_wr), .t_rdata(t_rdata)
  );

  fws_adapter #(
    .ADDR_W(AW), .DATA_W(DW)
  ) u_fws_adapter_zero (
    .clk(clk), .rst(rst), .h_addr(z_h_addr), .h_be(z_h_be), .h_wdata(z_h_wdata),
    .h_rd(z_h_rd), .h_wr(z_h_wr), .h_waitreq(z_h_waitreq), .h_rdata(z_h_rdata),
    .h_rdvalid(z_h_rdvalid), .t_cs(z_t_cs), .t_addr(z_t_addr), .t_be(z_t_be),
    .t_wdata(z_t_wdata), .t_rd(z_t_rd), .t_wr(z_t_wr), .t_rdata(z_t_rdata)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    vec_cnt++;
    if (!ok) begin
      mis_cnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scoreboard of target-side transactions
  typedef struct {
    logic          rd;
    logic [AW-1:0] addr;
    logic [BW-1:0] be;
    logic [DW-1:0] data;
  } exp_t;
  exp_t exp_q[$];

  bit            prev_done = 0;
  bit            rv_due = 0;
  logic [DW-1:0] rv_exp = '0;

  task automatic xfer(input bit rd, input bit wr, input logic [AW-1:0] a,
                      input logic [BW-1:0] be, input logic [DW-1:0] d,
                      input int gap);
    int stall, exp_stall, extra;
    exp_t it;
    repeat (gap) @(negedge clk);
    extra = prev_done ? ((HO > gap) ? HO - gap : 0) : 0;
    exp_stall = extra + 1 + SU + (rd ? RDW : WRW);
    it.rd = rd; it.addr = a; it.be = be; it.data = d;
    exp_q.push_back(it);
    @(negedge clk);
    h_addr = a; h_be = be; h_wdata = d; h_rd = rd; h_wr = wr;
    #1;
    stall = 0;
    while (h_waitreq) begin
      stall++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    h_rd = 1'b0; h_wr = 1'b0;
    if (rd) begin
      rv_exp = tgt_word(a);
      rv_due = 1;
    end
    prev_done = 1;
    // R3 (writes) / R4 (reads) / R5 (leftover hold) stall length
    check(stall == exp_stall, rd ? "R4 stall" : "R3 stall", stall, exp_stall);
  endtask

  // Read-return monitor (R4)
  always @(negedge clk) begin
    if (!rst) begin
      if (rv_due) begin
        check(h_rdvalid === 1'b1, "R4 rdvalid", h_rdvalid, 1);
        check(h_rdata === rv_exp, "R4 rdata", h_rdata, rv_exp);
        rv_due = 0;
      end else if (h_rdvalid) begin
        check(1'b0, "R4 spurious rdvalid", h_rdvalid, 0);
      end
    end
  end

  // Target-side monitor: measures phases and compares with the queue.
  bit            mon_act = 0, mon_seen = 0, mon_rd = 0, mon_stable = 1;
  int            mon_su = 0, mon_acc = 0, mon_ho = 0;
  logic [AW-1:0] mon_addr;
  logic [BW-1:0] mon_be;
  logic [DW-1:0] mon_wd;

  always @(negedge clk) begin
    if (!rst) begin
      if (t_cs) begin
        if (!mon_act) begin
          mon_act = 1; mon_seen = 0; mon_stable = 1;
          mon_su = 0; mon_acc = 0; mon_ho = 0; mon_rd = 0;
          mon_addr = t_addr; mon_be = t_be; mon_wd = t_wdata;
        end
        if (t_addr !== mon_addr || t_be !== mon_be || t_wdata !== mon_wd)
          mon_stable = 0;
        if (t_rd || t_wr) begin
          mon_acc++;
          mon_seen = 1;
          mon_rd = t_rd;
        end else if (mon_seen) mon_ho++;
        else mon_su++;
      end else if (mon_act) begin
        exp_t e;
        mon_act = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected target transaction", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(mon_su == SU, "R2 setup cycles", mon_su, SU);
          check(mon_acc == (e.rd ? RDW : WRW) + 1,
                e.rd ? "R4 strobe cycles" : "R3 strobe cycles",
                mon_acc, (e.rd ? RDW : WRW) + 1);
          check(mon_ho == HO, "R5 hold cycles", mon_ho, HO);
          check(mon_rd == e.rd, "R8 strobe kind", mon_rd, e.rd);
          check(mon_addr == e.addr, "R6 address", mon_addr, e.addr);
          check(mon_be == e.be, "R6 byteenable", mon_be, e.be);
          if (!e.rd) check(mon_wd == e.data, "R6 write data", mon_wd, e.data);
          check(mon_stable, "R10 fields stable", mon_stable, 1);
        end
      end
    end
  end

  // Zero-count instance driver (R7)
  task automatic zxfer(input bit rd, input logic [AW-1:0] a,
                       input logic [BW-1:0] be, input logic [DW-1:0] d);
    int stall;
    @(negedge clk);
    z_h_addr = a; z_h_be = be; z_h_wdata = d; z_h_rd = rd; z_h_wr = !rd;
    #1;
    stall = 0;
    while (z_h_waitreq) begin
      stall++;
      @(negedge clk);
      #1;
    end
    check(stall == 1, "R7 zero-count stall", stall, 1);
    if (rd) check(z_t_rd && !z_t_wr && z_t_addr == a, "R7 read strobe at completion",
                  {z_t_rd, z_t_wr}, 2'b10);
    else check(z_t_wr && !z_t_rd && z_t_wdata == d && z_t_be == be,
               "R7 write strobe at completion", z_t_wdata, d);
    @(posedge clk);
    #1;
    z_h_rd = 1'b0; z_h_wr = 1'b0;
    @(negedge clk);
    check(!z_t_rd && !z_t_wr, "R7 strobe one cycle", {z_t_rd, z_t_wr}, 0);
    if (rd) check(z_h_rdvalid && z_h_rdata == tgt_word(a), "R7 read data",
                  z_h_rdata, tgt_word(a));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, mis_cnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vec_cnt++;
    mis_cnt++;
    $display("FAIL R3 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!t_cs && !t_rd && !t_wr, "R1 reset strobes", {t_cs, t_rd, t_wr}, 0);
    check(!h_waitreq && !h_rdvalid, "R1 reset host side", {h_waitreq, h_rdvalid}, 0);
    check(!z_t_cs && !z_h_waitreq, "R1 reset zero instance", {z_t_cs, z_h_waitreq}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!t_cs && !h_waitreq, "R1 idle after reset", {t_cs, h_waitreq}, 0);

    xfer(0, 1, 16'h1234, 4'b0011, 32'hA5A5_0F0F, 0);   // R3, R6
    xfer(1, 0, 16'h0042, 4'b1111, 32'h0, 0);           // R4, R5 back-to-back
    xfer(0, 1, 16'hBEEF, 4'b1000, 32'h1357_9BDF, 1);   // R5 partial hold
    xfer(1, 0, 16'h8001, 4'b0101, 32'h0, 5);           // R4 from idle
    xfer(1, 1, 16'h7777, 4'b1111, 32'hFFFF_FFFF, 0);   // R8 read wins
    xfer(0, 1, 16'h0000, 4'b0000, 32'h0000_0001, 0);   // R6 empty byteenable
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R10 all transactions observed", exp_q.size(), 0);

    zxfer(0, 16'h00AA, 4'b0110, 32'hCAFE_F00D);        // R7
    zxfer(1, 16'h1111, 4'b1111, 32'h0);                // R7
    zxfer(1, 16'hF0F0, 4'b0001, 32'h0);                // R7
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule